// File: doc/BRIEF.md
# Self-Recentering Elastic Word Buffer

This block carries 16-bit parallel words from a write clock that is recovered from incoming data into a local read clock of the same nominal rate. Between the two sides sits an eight-entry circular store. The store soaks up slow phase wander of up to about one word period in either direction. The write pointer crosses into the read domain in Gray code through a two-flop synchronizer. All control runs in the read domain.

The pointers are brought back to their centred spacing in three cases. The first is when the active-low loss-of-lock input returns high. The second is when an external recenter request is released, provided it was held long enough. The third follows an overflow: when the observed pointer separation strays too far from centre, the block raises `overflow` for a fixed number of cycles, waits a fixed gap and then recenters. During that gap the words delivered may be corrupt. After every recenter, `rd_valid` stays low while a settling counter runs.

A read-domain state machine sequences the work. Its states are:
- **ST_UNLOCKED**: waits for lock while holding the write pointer at zero.
- **ST_HOLD**: holds the write pointer at zero until the read side sees it as zero.
- **ST_ALIGN**: waits for the write pointer to start moving, then places the read pointer.
- **ST_SETTLE**: runs the settling counter.
- **ST_RUN**: normal operation.
- **ST_OVF**: the overflow pulse.
- **ST_GAP**: the delay between the pulse and the recenter.

Its transitions are:
- unlock: any state to ST_UNLOCKED when `lock_n` is low.
- relock: ST_UNLOCKED to ST_HOLD.
- zeroed: ST_HOLD to ST_ALIGN.
- moving: ST_ALIGN to ST_SETTLE.
- settled: ST_SETTLE to ST_RUN.
- drift: ST_SETTLE or ST_RUN to ST_OVF.
- pulse_done: ST_OVF to ST_GAP.
- gap_done: ST_GAP to ST_HOLD.
- release: any state other than ST_UNLOCKED to ST_HOLD on a qualified request release.

The unlock transition has the highest priority, then release, then the per-state transitions.

Top module: `elastic_recenter_buf`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `rd_valid` and `overflow` are 0.
- R2: A low `lock_n` at a rising `rd_clk` edge forces `rd_valid` and `overflow` to 0 from the next cycle, for as long as it stays low.
- R3: When `lock_n` goes high the buffer recenters. `rd_valid` rises no sooner than SETTLE_CYC cycles and no later than SETTLE_CYC+30 cycles afterwards.
- R4: With the write clock wandering by less than one word period around the read clock, `overflow` stays 0, `rd_valid` stays 1, and each valid word is the previous valid word plus one (modulo 2^16) when the writer supplies an incrementing count.
- R5: `recenter_req` held high for REQ_MIN (default 4) or more cycles has no effect while high. `rd_valid` is 0 in the cycle after the first low sample.
- R6: `recenter_req` held high for fewer than REQ_MIN cycles is ignored, and `rd_valid` stays 1.
- R7: When the observed separation differs from its centre by more than DRIFT_LIM entries, `overflow` goes high for exactly OVF_PULSE (default 4) cycles.
- R8: After `overflow` falls, `rd_valid` stays 1 for exactly OVF_GAP (default 3) cycles and is 0 in the next one, when the recenter lands.
- R9: A new overflow detection during the pulse or the gap is ignored: each recenter is preceded by at most one `overflow` pulse.
- R10: After any recenter, `rd_valid` stays 0 for at least SETTLE_CYC cycles. Once it returns, the word stream is contiguous again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_clk | input | 1 | Write clock recovered from incoming data |
| wr_data | input | 16 | Parallel word captured on each `wr_clk` rising edge |
| rd_clk | input | 1 | Local read clock |
| lock_n | input | 1 | Active-low loss-of-lock indicator, synchronous to `rd_clk` |
| recenter_req | input | 1 | Active-high recenter request, synchronous to `rd_clk` |
| rd_data | output | 16 | Word delivered on `rd_clk` |
| rd_valid | output | 1 | High when the pointers are tracking and `rd_data` is trustworthy |
| overflow | output | 1 | Fixed-width pulse reporting excessive drift |

## Verification
The bench builds the block with SETTLE_CYC at 24 in place of roughly 1250. This makes the settling interval after every recenter short enough for the run to cover power-up lock, request release, lock loss and overflow recovery in sequence. All other parameters keep their defaults: eight entries, a centre of four, a drift limit of two, a 4-cycle request minimum, a 4-cycle pulse and a 3-cycle gap. With these values the exact pulse width, the exact gap and the short-request boundary are all measured at the ports. The write clock runs at 17 ns against a 20 ns read clock to push the drift past the limit quickly.

// File: rtl/erb_pkg.sv
package erb_pkg;

    typedef enum logic [2:0] {
        ST_UNLOCKED,
        ST_HOLD,
        ST_ALIGN,
        ST_SETTLE,
        ST_RUN,
        ST_OVF,
        ST_GAP
    } erb_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/erb_sync.sv
module erb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/erb_wr_side.sv
module erb_wr_side #(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              hold_req,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] wr_gray
);
    logic              hold_s;
    logic [ADDR_W-1:0] ptr_nx;

    erb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_hold_sync (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (hold_req),
        .q     (hold_s)
    );

    assign ptr_nx = hold_s ? '0 : wr_ptr + ADDR_W'(1);

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wr_gray <= '0;
        end else begin
            wr_ptr  <= ptr_nx;
            wr_gray <= ptr_nx ^ (ptr_nx >> 1);
        end
    end
endmodule

// File: rtl/erb_store.sv
module erb_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/erb_req_qual.sv
module erb_req_qual #(
    parameter int REQ_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic fire
);
    localparam int RW = $clog2(REQ_MIN + 1);

    logic [RW-1:0] run;
    logic          req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= req;
            if (!req) begin
                run <= '0;
            end else if (run != RW'(REQ_MIN)) begin
                run <= run + RW'(1);
            end
        end
    end

    assign fire = !req && req_q && (run == RW'(REQ_MIN));
endmodule

// File: rtl/erb_rd_fsm.sv
module erb_rd_fsm
    import erb_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CENTER      = 4,
    parameter int DRIFT_LIM   = 2,
    parameter int OVF_PULSE   = 4,
    parameter int OVF_GAP     = 3,
    parameter int SETTLE_CYC  = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_n,
    input  logic              req_fire,
    input  logic [ADDR_W-1:0] wr_gray_s,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              hold_req,
    output logic              rd_valid,
    output logic              overflow
);
    localparam int OBS_CENTER = CENTER - SYNC_STAGES;
    localparam int HOLD_MIN   = 2 * SYNC_STAGES + 2;
    localparam int CNT_MAX    = imax(imax(SETTLE_CYC, HOLD_MIN), imax(OVF_PULSE, OVF_GAP));
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic signed [ADDR_W-1:0] LIM_P = ADDR_W'(DRIFT_LIM);
    localparam logic signed [ADDR_W-1:0] LIM_N = ADDR_W'(-DRIFT_LIM);
    localparam logic [ADDR_W-1:0]        OBS_C = ADDR_W'(OBS_CENTER);

    erb_state_e               state, state_nx;
    logic [CNT_W-1:0]         cnt;
    logic [ADDR_W-1:0]        wr_bin_s;
    logic [ADDR_W-1:0]        sep;
    logic signed [ADDR_W-1:0] dev;
    logic                     drift_bad;

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            wr_bin_s[i] = ^(wr_gray_s >> i);
        end
    end

    assign sep       = wr_bin_s - rd_ptr;
    assign dev       = sep - OBS_C;
    assign drift_bad = (dev > LIM_P) || (dev < LIM_N);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_UNLOCKED;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_UNLOCKED: if (lock_n) state_nx = ST_HOLD;
            ST_HOLD:     if (cnt >= CNT_W'(HOLD_MIN - 1) && wr_bin_s == '0) state_nx = ST_ALIGN;
            ST_ALIGN:    if (wr_bin_s != '0) state_nx = ST_SETTLE;
            ST_SETTLE: begin
                if (drift_bad) begin
                    state_nx = ST_OVF;
                end else if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN:      if (drift_bad) state_nx = ST_OVF;
            ST_OVF:      if (cnt == CNT_W'(OVF_PULSE - 1)) state_nx = ST_GAP;
            ST_GAP:      if (cnt == CNT_W'(OVF_GAP - 1)) state_nx = ST_HOLD;
            default:     state_nx = ST_UNLOCKED;
        endcase
        if (req_fire && state != ST_UNLOCKED) begin
            state_nx = ST_HOLD;
        end
        if (!lock_n) begin
            state_nx = ST_UNLOCKED;
        end
    end

    // dwell counter and read pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rd_ptr <= '0;
        end else begin
            if (state_nx != state) begin
                cnt <= '0;
            end else if (cnt != {CNT_W{1'b1}}) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (state == ST_ALIGN && state_nx == ST_SETTLE) begin
                rd_ptr <= wr_bin_s - OBS_C + ADDR_W'(1);
            end else if (state == ST_SETTLE || state == ST_RUN ||
                         state == ST_OVF || state == ST_GAP) begin
                rd_ptr <= rd_ptr + ADDR_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        hold_req = (state == ST_UNLOCKED) || (state == ST_HOLD);
        overflow = (state == ST_OVF);
        rd_valid = (state == ST_RUN) || (state == ST_OVF) || (state == ST_GAP);
    end
endmodule

// File: rtl/elastic_recenter_buf.sv
module elastic_recenter_buf #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int CENTER      = 4,
    parameter int DRIFT_LIM   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int REQ_MIN     = 4,
    parameter int OVF_PULSE   = 4,
    parameter int OVF_GAP     = 3,
    parameter int SETTLE_CYC  = 1250
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              lock_n,
    input  logic              recenter_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              overflow
);
    logic [ADDR_W-1:0] wr_ptr, wr_gray, wr_gray_s, rd_ptr;
    logic              hold_req, req_fire;

    erb_wr_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .wr_clk   (wr_clk),
        .rst_n    (rst_n),
        .hold_req (hold_req),
        .wr_ptr   (wr_ptr),
        .wr_gray  (wr_gray)
    );

    erb_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_ptr_sync (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    erb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wr_clk  (wr_clk),
        .wr_addr (wr_ptr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    erb_req_qual #(.REQ_MIN(REQ_MIN)) u_req (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .req   (recenter_req),
        .fire  (req_fire)
    );

    erb_rd_fsm #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES),
        .CENTER      (CENTER),
        .DRIFT_LIM   (DRIFT_LIM),
        .OVF_PULSE   (OVF_PULSE),
        .OVF_GAP     (OVF_GAP),
        .SETTLE_CYC  (SETTLE_CYC)
    ) u_fsm (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .lock_n    (lock_n),
        .req_fire  (req_fire),
        .wr_gray_s (wr_gray_s),
        .rd_ptr    (rd_ptr),
        .hold_req  (hold_req),
        .rd_valid  (rd_valid),
        .overflow  (overflow)
    );
endmodule

// File: rtl/erb_chk.sv
module erb_chk #(
    parameter int OVF_PULSE  = 4,
    parameter int OVF_GAP    = 3,
    parameter int SETTLE_CYC = 1250
) (
    input logic clk,
    input logic rst_n,
    input logic lock_n,
    input logic recenter_req,
    input logic rd_valid,
    input logic overflow
);
    int   ovf_run;
    int   gap_cnt;
    int   low_run;
    logic gap_track;
    logic busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_run   <= 0;
            gap_cnt   <= 0;
            low_run   <= 0;
            gap_track <= 1'b0;
            busy      <= 1'b0;
        end else begin
            ovf_run <= overflow ? ovf_run + 1 : 0;
            if (rd_valid) begin
                low_run <= 0;
            end else if (low_run < SETTLE_CYC) begin
                low_run <= low_run + 1;
            end
            if (!lock_n || recenter_req || !rd_valid) begin
                gap_track <= 1'b0;
            end else if (overflow) begin
                gap_track <= 1'b1;
                gap_cnt   <= 0;
            end else if (gap_track) begin
                gap_cnt <= gap_cnt + 1;
            end
            if (overflow) begin
                busy <= 1'b1;
            end else if (!rd_valid) begin
                busy <= 1'b0;
            end
        end
    end

    a_r2_unlock_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n |=> (!rd_valid && !overflow));

    a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overflow) |-> (ovf_run == OVF_PULSE));

    a_r8_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_valid) && gap_track && $past(lock_n) && !$past(overflow)) |-> (gap_cnt == OVF_GAP));

    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> !busy);

    a_r10_settle_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_valid) && !overflow) |-> (low_run >= SETTLE_CYC));
endmodule

bind elastic_recenter_buf erb_chk #(
    .OVF_PULSE  (OVF_PULSE),
    .OVF_GAP    (OVF_GAP),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk          (rd_clk),
    .rst_n        (rst_n),
    .lock_n       (lock_n),
    .recenter_req (recenter_req),
    .rd_valid     (rd_valid),
    .overflow     (overflow)
);

// File: tb/tb_elastic_recenter_buf.sv
`timescale 1ns/1ps
module tb_elastic_recenter_buf;
    localparam int SETTLE = 24;
    localparam int ROWS = 6;
    // stimulus: write-clock period (ns) and read cycles; expected: overflow samples, breaks
    localparam int ROW_PER [ROWS] = '{20, 21, 20, 19, 20, 21};
    localparam int ROW_CYC [ROWS] = '{40, 12, 30, 24, 30, 12};
    localparam int ROW_OVF [ROWS] = '{0, 0, 0, 0, 0, 0};
    localparam int ROW_BRK [ROWS] = '{0, 0, 0, 0, 0, 0};

    logic        rst_n, wr_clk, rd_clk, lock_n, recenter_req;
    logic [15:0] wr_data, rd_data;
    logic        rd_valid, overflow;
    realtime     wr_half;

    int checks = 0, errors = 0;
    int breaks = 0, ovf_seen = 0;
    bit chk_cont = 0, prev_v = 0;
    logic [15:0] prev_d = '0;

    elastic_recenter_buf #(.SETTLE_CYC(SETTLE)) dut (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_data(wr_data), .rd_clk(rd_clk),
        .lock_n(lock_n), .recenter_req(recenter_req),
        .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow)
    );

    initial begin
        rd_clk = 0;
        forever #10 rd_clk = ~rd_clk;
    end

    initial begin
        wr_clk  = 0;
        wr_data = '0;
        wr_half = 10.0;
        #7;
        forever begin
            #(wr_half) wr_clk = 1;
            #(wr_half) wr_clk = 0;
            wr_data = wr_data + 16'd1;
        end
    end

    always @(negedge rd_clk) begin
        if (chk_cont && prev_v && rd_valid && rd_data != prev_d + 16'd1) breaks++;
        if (overflow) ovf_seen++;
        prev_v = rd_valid;
        prev_d = rd_data;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_valid(output int n, input int lim);
        n = 0;
        while (!rd_valid && n < lim) begin
            @(negedge rd_clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge rd_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, lows, b0, o0, hi, gap, rises;
        rst_n = 0; lock_n = 0; recenter_req = 0;
        repeat (5) @(negedge rd_clk);
        check(rd_valid == 0 && overflow == 0, "R1", "outputs in reset", {rd_valid, overflow}, 0);
        rst_n = 1;
        @(negedge rd_clk);
        check(rd_valid == 0 && overflow == 0, "R1", "outputs after reset", {rd_valid, overflow}, 0);

        // R2: lock held low keeps output blanked
        lows = 0;
        repeat (20) begin
            @(negedge rd_clk);
            if (rd_valid || overflow) lows++;
        end
        check(lows == 0, "R2", "active samples while unlocked", lows, 0);

        // R3: lock acquired recenters and settles
        lock_n = 1;
        wait_valid(n, 200);
        check(n >= SETTLE && n <= SETTLE + 30, "R3", "cycles lock to valid", n, SETTLE);
        chk_cont = 1;
        repeat (10) @(negedge rd_clk);

        // R4: table of wander within tolerance
        for (int r = 0; r < ROWS; r++) begin
            b0 = breaks; o0 = ovf_seen;
            wr_half = ROW_PER[r] / 2.0;
            repeat (ROW_CYC[r]) @(negedge rd_clk);
            check(breaks - b0 == ROW_BRK[r], "R4", $sformatf("row %0d data breaks", r), breaks - b0, ROW_BRK[r]);
            check(ovf_seen - o0 == ROW_OVF[r], "R4", $sformatf("row %0d overflow samples", r), ovf_seen - o0, ROW_OVF[r]);
            check(rd_valid == 1, "R4", $sformatf("row %0d valid", r), rd_valid, 1);
        end
        wr_half = 10.0;
        repeat (10) @(negedge rd_clk);

        // R6: request too short ignored
        lows = 0;
        recenter_req = 1;
        repeat (3) begin
            @(negedge rd_clk);
            if (!rd_valid) lows++;
        end
        recenter_req = 0;
        repeat (10) begin
            @(negedge rd_clk);
            if (!rd_valid) lows++;
        end
        check(lows == 0, "R6", "invalid samples after short request", lows, 0);

        // R5: qualified request recenters after release
        lows = 0;
        recenter_req = 1;
        repeat (4) begin
            @(negedge rd_clk);
            if (!rd_valid) lows++;
        end
        check(lows == 0, "R5", "invalid samples while request high", lows, 0);
        recenter_req = 0;
        @(negedge rd_clk);
        check(rd_valid == 0, "R5", "valid after release", rd_valid, 0);
        wait_valid(n, 200);
        check(n >= SETTLE - 1, "R10", "settle after request", n, SETTLE);
        b0 = breaks;
        repeat (30) @(negedge rd_clk);
        check(breaks == b0 && rd_valid, "R10", "stream after request recenter", breaks - b0, 0);

        // R2/R3: lock loss mid-run
        lock_n = 0;
        @(negedge rd_clk);
        check(rd_valid == 0 && overflow == 0, "R2", "outputs after lock loss", {rd_valid, overflow}, 0);
        repeat (5) @(negedge rd_clk);
        lock_n = 1;
        wait_valid(n, 200);
        check(n >= SETTLE && n <= SETTLE + 30, "R3", "cycles relock to valid", n, SETTLE);
        b0 = breaks;
        repeat (30) @(negedge rd_clk);
        check(breaks == b0 && rd_valid, "R10", "stream after relock", breaks - b0, 0);

        // R7/R8/R9: drift past the limit
        chk_cont = 0;
        wr_half = 8.5;
        n = 0;
        while (!overflow && n < 400) begin
            @(negedge rd_clk);
            n++;
        end
        check(overflow == 1, "R7", "overflow raised by drift", overflow, 1);
        hi = 0;
        while (overflow && hi < 50) begin
            hi++;
            @(negedge rd_clk);
        end
        check(hi == 4, "R7", "overflow pulse width", hi, 4);
        gap = 0; rises = 0;
        while (rd_valid && gap < 50) begin
            if (overflow) rises++;
            else gap++;
            @(negedge rd_clk);
        end
        check(gap == 3, "R8", "cycles from overflow fall to recenter", gap, 3);
        check(rises == 0, "R9", "overflow samples during gap", rises, 0);
        wr_half = 10.0;
        wait_valid(n, 200);
        check(n >= SETTLE, "R10", "settle after overflow", n, SETTLE);
        chk_cont = 1;
        b0 = breaks; o0 = ovf_seen;
        repeat (40) @(negedge rd_clk);
        check(breaks == b0 && ovf_seen == o0 && rd_valid, "R10", "stream after overflow recenter", breaks - b0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule